// File: doc/BRIEF.md
# Multiplexed External Memory Read Sequencer

This block fetches 16-bit words from an external program memory that shares one bus between the low address and the returned data. The block runs on a phase clock at four times the instruction rate, so each instruction cycle has four phases. Every read takes exactly four phase clocks. In the first phase the block drives the address and pulses the address-latch strobe. In the second phase it lets go of the shared bus. In the last two phases it holds the output-enable strobe low, and it samples the bus as output enable returns high.

The requester presents a 20-bit word address with a one-clock start request. It may do this whenever `reqReady` is high. A request taken in the final phase of a read starts the next read straight away, with no idle phase, so reads can run back to back. Each finished read gives a one-clock valid pulse that carries the word and the address it came from. The shared bus is modelled as separate output, output-enable and input vectors. The pad that merges them lives outside this block.

Top module: `xmem_read_seq`

## Requirements
- R1: After synchronous reset, and at any later idle time, the outputs are: `ale`=0, `ceN`=1, `oeN`=1, `adOe`=0, `rdValid`=0, `reqReady`=1.
- R2: One phase clock after an accepted request (`startReq`=1 while `reqReady`=1), `ale`=1, `adOe`=1 and `adOut` equals address bits 15..0. `ale` stays high for exactly one phase clock, and it never rises without an accepted request in the previous clock.
- R3: From the first through the fourth phase, `addrHi` shows address bits 19..16 of the read in progress and does not change.
- R4: In the second phase, `adOe`=0 and `oeN`=1, so the bus is released a full phase before output enable falls.
- R5: In the third and fourth phases, `oeN`=0. While `oeN` is low, `adOe` and `ale` are both 0. Each output-enable pulse lasts exactly two phase clocks.
- R6: `ceN` is 0 in all four phases of a read and 1 otherwise.
- R7: `adIn` is sampled in the fourth phase. One phase clock later, `rdValid` pulses for one clock, with `rdData` equal to that sample and `rdAddr` equal to the requested 20-bit address.
- R8: `reqReady` is 1 when idle and in the fourth phase. A request taken in the fourth phase puts the next first phase in the very next clock, so address-latch pulses are four clocks apart.
- R9: A request made while `reqReady`=0 (phases one to three) is ignored. It produces no extra read and does not change the address of the read in progress.
- R10: Asserting `rst` during a read aborts it. The next clock shows the idle outputs of R1, and no valid pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, four per instruction cycle |
| rst | input | 1 | Synchronous active-high reset |
| startReq | input | 1 | Read request, taken when reqReady is high |
| reqAddr | input | ADDR_W | Word address of the request |
| reqReady | output | 1 | Request can be accepted this clock |
| addrHi | output | ADDR_W-AD_W | Upper address bits on their dedicated port |
| adOut | output | AD_W | Low address driven onto the shared bus |
| adOe | output | 1 | Block drives the shared bus |
| adIn | input | AD_W | Value read back from the shared bus |
| ale | output | 1 | Address latch enable, active high |
| ceN | output | 1 | Chip enable, active low |
| oeN | output | 1 | Output enable, active low |
| rdValid | output | 1 | One-clock pulse: read finished |
| rdData | output | AD_W | Word captured from the bus |
| rdAddr | output | ADDR_W | Address the word belongs to |

## Verification
The bench builds the block with its default widths: a 20-bit address over a 16-bit shared bus, which leaves a 4-bit upper port. Random 32-bit draws truncated to 20 bits reach every upper-nibble value, and a data function that mixes the upper bits into the word exposes any mix-up between the two address ports. Because requests arrive on about two clocks in three, Q4 chaining and ignored mid-read requests occur hundreds of times. A reset timed into the third phase shows that the in-flight read is dropped.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_Q1,
    PH_Q2,
    PH_Q3,
    PH_Q4
  } phase_e;

  // strobes from control to datapath and pins, all active high
  typedef struct packed {
    logic load;     // latch the new request address
    logic ale;      // address latch pulse
    logic drvAd;    // own the shared bus
    logic ce;       // chip selected
    logic oe;       // memory may drive the bus
    logic capture;  // sample bus, last phase
  } strobe_t;

endpackage

// File: rtl/xmem_ctrl.sv
module xmem_ctrl
  import xmem_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    startReq,
  output logic    reqReady,
  output strobe_t strb
);

  phase_e phase, phaseNxt;
  logic   accept;

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_IDLE;
    else     phase <= phaseNxt;
  end

  always_comb begin
    reqReady = (phase == PH_IDLE) || (phase == PH_Q4);
    accept   = startReq && reqReady;
    unique case (phase)
      PH_IDLE: phaseNxt = accept ? PH_Q1 : PH_IDLE;
      PH_Q1:   phaseNxt = PH_Q2;
      PH_Q2:   phaseNxt = PH_Q3;
      PH_Q3:   phaseNxt = PH_Q4;
      PH_Q4:   phaseNxt = accept ? PH_Q1 : PH_IDLE;
      default: phaseNxt = PH_IDLE;
    endcase
  end

  always_comb begin
    strb.load    = accept;
    strb.ale     = (phase == PH_Q1);
    strb.drvAd   = (phase == PH_Q1);
    strb.ce      = (phase != PH_IDLE);
    strb.oe      = (phase == PH_Q3) || (phase == PH_Q4);
    strb.capture = (phase == PH_Q4);
  end

endmodule

// File: rtl/xmem_dpath.sv
module xmem_dpath #(
  parameter int ADDR_W = 20,
  parameter int AD_W   = 16,
  localparam int HI_W  = ADDR_W - AD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              drvAd,
  input  logic              capture,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [AD_W-1:0]   adIn,
  output logic [HI_W-1:0]   addrHi,
  output logic [AD_W-1:0]   adOut,
  output logic              adOe,
  output logic              rdValid,
  output logic [AD_W-1:0]   rdData,
  output logic [ADDR_W-1:0] rdAddr
);

  logic [ADDR_W-1:0] addrReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrReg <= '0;
      rdValid <= 1'b0;
      rdData  <= '0;
      rdAddr  <= '0;
    end else begin
      if (load) addrReg <= reqAddr;
      rdValid <= capture;
      if (capture) begin
        rdData <= adIn;
        rdAddr <= addrReg;
      end
    end
  end

  assign addrHi = addrReg[ADDR_W-1:AD_W];
  assign adOut  = drvAd ? addrReg[AD_W-1:0] : '0;
  assign adOe   = drvAd;

endmodule

// File: rtl/xmem_read_seq.sv
module xmem_read_seq
  import xmem_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int AD_W   = 16,
  localparam int HI_W  = ADDR_W - AD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              startReq,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              reqReady,
  output logic [HI_W-1:0]   addrHi,
  output logic [AD_W-1:0]   adOut,
  output logic              adOe,
  input  logic [AD_W-1:0]   adIn,
  output logic              ale,
  output logic              ceN,
  output logic              oeN,
  output logic              rdValid,
  output logic [AD_W-1:0]   rdData,
  output logic [ADDR_W-1:0] rdAddr
);

  strobe_t strb;

  xmem_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .startReq (startReq),
    .reqReady (reqReady),
    .strb     (strb)
  );

  xmem_dpath #(.ADDR_W(ADDR_W), .AD_W(AD_W)) dpath_i (
    .clk     (clk),
    .rst     (rst),
    .load    (strb.load),
    .drvAd   (strb.drvAd),
    .capture (strb.capture),
    .reqAddr (reqAddr),
    .adIn    (adIn),
    .addrHi  (addrHi),
    .adOut   (adOut),
    .adOe    (adOe),
    .rdValid (rdValid),
    .rdData  (rdData),
    .rdAddr  (rdAddr)
  );

  assign ale = strb.ale;
  assign ceN = ~strb.ce;
  assign oeN = ~strb.oe;

endmodule

// File: rtl/xmem_read_seq_chk.sv
module xmem_read_seq_chk #(
  parameter int HI_W = 4
) (
  input logic            clk,
  input logic            rst,
  input logic [HI_W-1:0] addrHi,
  input logic            adOe,
  input logic            ale,
  input logic            ceN,
  input logic            oeN,
  input logic            rdValid
);

  p_ale_one_phase_r2: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale);

  p_hi_stable_r3: assert property (@(posedge clk) disable iff (rst)
    (!ceN && !ale) |-> $stable(addrHi));

  p_release_before_oe_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(oeN) |-> $past(!adOe));

  p_oe_no_drive_r5: assert property (@(posedge clk) disable iff (rst)
    !oeN |-> (!adOe && !ale));

  p_oe_two_phases_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(oeN) |=> !oeN);

  p_oe_ends_r5: assert property (@(posedge clk) disable iff (rst)
    (!oeN && $past(!oeN)) |=> oeN);

  p_ce_covers_oe_r6: assert property (@(posedge clk) disable iff (rst)
    !oeN |-> !ceN);

  p_valid_after_oe_r7: assert property (@(posedge clk) disable iff (rst)
    rdValid |-> ($past(!oeN) && oeN));

  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    rdValid |=> !rdValid);

endmodule

bind xmem_read_seq xmem_read_seq_chk #(.HI_W(HI_W)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .addrHi  (addrHi),
  .adOe    (adOe),
  .ale     (ale),
  .ceN     (ceN),
  .oeN     (oeN),
  .rdValid (rdValid)
);

// File: tb/xmem_read_seq_tb_top.sv
`timescale 1ns/1ps
module xmem_read_seq_tb_top;

  localparam int ADDR_W = 20;
  localparam int AD_W   = 16;
  localparam int HI_W   = ADDR_W - AD_W;
  localparam int QD     = 1024;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              startReq = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic              reqReady;
  logic [HI_W-1:0]   addrHi;
  logic [AD_W-1:0]   adOut;
  logic              adOe;
  logic [AD_W-1:0]   adIn;
  logic              ale, ceN, oeN, rdValid;
  logic [AD_W-1:0]   rdData;
  logic [ADDR_W-1:0] rdAddr;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2 clk = ~clk;

  xmem_read_seq #(.ADDR_W(ADDR_W), .AD_W(AD_W)) dut_i (
    .clk(clk), .rst(rst), .startReq(startReq), .reqAddr(reqAddr),
    .reqReady(reqReady), .addrHi(addrHi), .adOut(adOut), .adOe(adOe),
    .adIn(adIn), .ale(ale), .ceN(ceN), .oeN(oeN), .rdValid(rdValid),
    .rdData(rdData), .rdAddr(rdAddr)
  );

  function automatic logic [AD_W-1:0] memWord(logic [ADDR_W-1:0] a);
    return a[15:0] ^ {a[19:16], a[19:16], 8'hA5} ^ {a[7:0], a[15:8]};
  endfunction

  // memory model: latch address while ALE is high, drive when OE low
  logic [ADDR_W-1:0] memLatch = '0;
  always @(negedge clk) if (ale) memLatch = {addrHi, adOut};
  assign adIn = !oeN ? memWord(memLatch) : 16'hBEEF;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // expected-read queue
  logic [ADDR_W-1:0] expQ [QD];
  int qHead = 0, qTail = 0;

  logic              wantAcc = 1'b0;
  logic [ADDR_W-1:0] pendAddr = '0;
  logic              acceptQ = 1'b0, rstQ = 1'b1;
  logic [ADDR_W-1:0] curAddr = '0;
  int                phCnt = 0, prevPh = 0;
  int                validCnt = 0;

  always @(posedge clk) begin
    cyc++;
    acceptQ <= wantAcc && !rst;
    rstQ    <= rst;
    if (wantAcc && !rst) curAddr <= pendAddr;
  end

  // reference model of the phase schedule
  always @(negedge clk) begin
    prevPh = phCnt;
    if (rstQ) begin
      phCnt = 0;
      qHead = qTail;
    end else if (acceptQ) phCnt = 1;
    else if (phCnt >= 1 && phCnt <= 3) phCnt++;
    else phCnt = 0;

    if (rstQ && !rst) begin
      chk(!ale && ceN && oeN && !adOe && !rdValid && reqReady,
          "R1/R10 idle after reset", {ale, ceN, oeN, adOe, rdValid, reqReady}, 6'b011001);
    end else if (!rst) begin
      chk(ale == (phCnt == 1), "R2 ale", ale, phCnt == 1);
      chk(ceN == (phCnt == 0), "R6 ceN", ceN, phCnt == 0);
      if (phCnt == 1)
        chk(adOe && adOut == curAddr[15:0], "R2 address on bus", adOut, curAddr[15:0]);
      if (phCnt == 2)
        chk(!adOe && oeN, "R4 bus released", {adOe, oeN}, 2'b01);
      if (phCnt >= 3)
        chk(!oeN && !adOe, "R5 oe low, bus released", {oeN, adOe}, 2'b00);
      if (phCnt <= 2)
        chk(oeN, "R5 oe high outside Q3/Q4", oeN, 1);
      if (phCnt != 0)
        chk(addrHi == curAddr[19:16], "R3 upper address", addrHi, curAddr[19:16]);
      chk(reqReady == (phCnt == 0 || phCnt == 4), "R8 reqReady", reqReady, phCnt == 0 || phCnt == 4);
      if (prevPh == 4 && phCnt == 1)
        chk(ale, "R8 chained Q1 right after Q4", ale, 1);
      chk(rdValid == (prevPh == 4), "R7 valid pulse timing", rdValid, prevPh == 4);
      if (rdValid) begin
        validCnt++;
        if (qHead == qTail) chk(0, "R9 unexpected read", rdAddr, 0);
        else begin
          chk(rdAddr == expQ[qHead % QD], "R7 rdAddr", rdAddr, expQ[qHead % QD]);
          chk(rdData == memWord(expQ[qHead % QD]), "R7 rdData", rdData, memWord(expQ[qHead % QD]));
          qHead++;
        end
      end
    end
  end

  task automatic drive(bit s, logic [ADDR_W-1:0] a);
    @(negedge clk);
    startReq = s;
    reqAddr  = a;
    wantAcc  = s && reqReady && !rst;
    pendAddr = a;
    if (wantAcc) begin
      expQ[qTail % QD] = a;
      qTail++;
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin : stim
    int vBefore;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    drive(0, '0);
    // R1: idle state checked directly
    chk(!ale && ceN && oeN && !adOe && reqReady && !rdValid, "R1 reset state",
        {ale, ceN, oeN, adOe, reqReady, rdValid}, 6'b011010);

    // single read, then idle
    drive(1, 20'hABCDE);
    repeat (6) drive(0, '0);

    // back-to-back: request in Q4 of each read (R8)
    drive(1, 20'h12345);
    repeat (3) drive(0, '0);
    drive(1, 20'hF0F0F);
    repeat (3) drive(0, '0);
    drive(1, 20'h00001);
    repeat (6) drive(0, '0);

    // requests in Q1..Q3 ignored (R9)
    vBefore = validCnt;
    drive(1, 20'h55AA3);
    drive(1, 20'h11111);
    drive(1, 20'h22222);
    drive(1, 20'h33333);
    drive(0, '0);
    repeat (4) drive(0, '0);
    chk(validCnt - vBefore == 1, "R9 one read for four requests", validCnt - vBefore, 1);

    // reset in Q3 aborts the read (R10)
    vBefore = validCnt;
    drive(1, 20'h7E7E7);
    drive(0, '0);
    drive(0, '0);
    @(negedge clk);
    rst = 1'b1; startReq = 1'b0; wantAcc = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    repeat (5) drive(0, '0);
    chk(validCnt == vBefore, "R10 no valid after abort", validCnt - vBefore, 0);

    // constrained random traffic
    for (int i = 0; i < 1500; i++)
      drive(($urandom % 3) != 0, ADDR_W'($urandom));
    repeat (8) drive(0, '0);
    chk(qHead == qTail, "R7 all reads returned", qTail - qHead, 0);
    finishRun();
  end

endmodule